// File: doc/BRIEF.md
# Command byte decoder

This block turns a stream of bytes, one per clock on an 8-bit bus, into register-write commands for a local register set. A command is a short burst of consecutive bytes: two address bytes followed by the data bytes. A marker input, high only with the first byte, tells the block where a command begins. The full 16-bit address is compared with a base address under a mask. If they match, the block presents a narrow local register address, the assembled data word and a write enable that lasts one clock.

Many copies of the block can listen to one shared byte bus. Each copy gets its own base and mask, so each accepts only the commands meant for its own registers and ignores the rest. Everything runs in one clock domain with a synchronous, active-high reset. The number of bytes in a command is a parameter from 3 to 6. This sets the data word to 8 to 32 bits.

Top module: `cmd_byte_decoder`

## Requirements
- R1: A command is a run of FRAME_BYTES consecutive bytes. Byte 0 is the low address byte and byte 1 is the high address byte. The remaining bytes are data.
- R2: `cmd_first` is high only with byte 0. When no command is in progress, bytes that arrive without `cmd_first` are ignored and produce no write.
- R3: A command is accepted when `(addr & ADDR_MASK) == (BASE_ADDR & ADDR_MASK)`, where `addr` is the full 16-bit address. Address bits that the mask clears do not affect acceptance.
- R4: A command that is not accepted produces no `wr_en`, and `wr_addr` and `wr_data` keep their previous values.
- R5: For an accepted command, `wr_en` is high for exactly one cycle. It rises on the clock edge that captures the last byte, and outputs are valid in that same cycle. Two commands sent back to back give two separate pulses.
- R6: Data is assembled little-endian. The first data byte goes to bits 7:0 and each later byte goes to the next higher eight bits. With six bytes, the last byte lands in bits 31:24.
- R7: `wr_addr` equals the low LOCAL_AW bits of the accepted command's address (bits 3:0 by default).
- R8: If `cmd_first` arrives while a command is still in progress, the partial command is dropped. Collection restarts with that byte as the low address byte.
- R9: Synchronous reset clears `wr_en`, `wr_addr`, `wr_data` and the byte position. After reset, the remaining bytes of an interrupted command cause no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_byte | input | 8 | Command byte, one per cycle |
| cmd_first | input | 1 | High with the first byte of a command |
| wr_addr | output | LOCAL_AW | Local register address of the last accepted command |
| wr_data | output | DATA_W | Data word of the last accepted command (DATA_W = 8*(FRAME_BYTES-2)) |
| wr_en | output | 1 | One-cycle write enable |

## Verification
The hardest situations to reach are the ones where framing breaks. One is a new first-byte marker arriving partway through a command. The other is a reset landing between two bytes of one command, after which the rest of that command keeps coming. The bench reaches both with a task that drives any sub-range of a command's bytes. It sends the first half of one command, then either a fresh complete command or a reset followed by the second half. It then checks that exactly the expected number of write pulses appeared and that the outputs hold the expected words.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
   localparam int BYTE_W     = 8;
   localparam int ADDR_BYTES = 2;
   localparam int ADDR_W     = BYTE_W * ADDR_BYTES;
   localparam int MIN_FRAME  = ADDR_BYTES + 1;
   localparam int MAX_FRAME  = ADDR_BYTES + 4;

   typedef logic [BYTE_W-1:0] cbd_byte_t;
   typedef logic [ADDR_W-1:0] cbd_addr_t;
endpackage

// File: rtl/cbd_framer.sv
// Tracks the position of the current byte within a command.
module cbd_framer
   import cbd_pkg::*;
#(
   parameter int FRAME_BYTES = 6,
   localparam int POS_W = $clog2(FRAME_BYTES)
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             first,
   output logic [POS_W-1:0] slot,
   output logic             slot_vld,
   output logic             frame_end,
   output logic [POS_W-1:0] pos_q
);
   localparam logic [POS_W-1:0] LAST_SLOT = POS_W'(FRAME_BYTES - 1);

   // A marker always forces slot 0, so a marker mid-frame restarts collection.
   always_comb begin
      slot_vld  = first || (pos_q != '0);
      slot      = first ? '0 : pos_q;
      frame_end = slot_vld && (slot == LAST_SLOT);
   end

   always_ff @(posedge clk) begin
      if (rst)
         pos_q <= '0;
      else if (slot_vld)
         pos_q <= frame_end ? '0 : slot + 1'b1;
   end
endmodule

// File: rtl/cbd_collect.sv
// Stores address bytes and data bytes into their slots.
module cbd_collect
   import cbd_pkg::*;
#(
   parameter int FRAME_BYTES = 6,
   localparam int POS_W  = $clog2(FRAME_BYTES),
   localparam int DBYTES = FRAME_BYTES - ADDR_BYTES,
   localparam int DATA_W = BYTE_W * DBYTES
)(
   input  logic              clk,
   input  logic              rst,
   input  cbd_byte_t         din,
   input  logic [POS_W-1:0]  slot,
   input  logic              slot_vld,
   output cbd_addr_t         addr_q,
   output logic [DATA_W-1:0] data_next
);
   logic [ADDR_BYTES-1:0] a_sel;
   logic [DBYTES-1:0]     d_sel;
   logic [DATA_W-1:0]     data_q;

   for (genvar a = 0; a < ADDR_BYTES; a++) begin : g_asel
      assign a_sel[a] = slot_vld && (slot == POS_W'(a));
   end

   // The data word seen by the decoder already includes the byte arriving now.
   for (genvar j = 0; j < DBYTES; j++) begin : g_dsel
      assign d_sel[j] = slot_vld && (slot == POS_W'(j + ADDR_BYTES));
      assign data_next[j*BYTE_W +: BYTE_W] =
         d_sel[j] ? din : data_q[j*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         data_q <= '0;
      end else begin
         for (int a = 0; a < ADDR_BYTES; a++)
            if (a_sel[a]) addr_q[a*BYTE_W +: BYTE_W] <= din;
         data_q <= data_next;
      end
   end
endmodule

// File: rtl/cbd_decode.sv
// Masked address compare and output registers.
module cbd_decode
   import cbd_pkg::*;
#(
   parameter cbd_addr_t BASE_ADDR = 16'h0140,
   parameter cbd_addr_t ADDR_MASK = 16'hFFF0,
   parameter int        LOCAL_AW  = 4,
   parameter int        DATA_W    = 32
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                frame_end,
   input  cbd_addr_t           addr,
   input  logic [DATA_W-1:0]   data_in,
   output logic [LOCAL_AW-1:0] wr_addr,
   output logic [DATA_W-1:0]   wr_data,
   output logic                wr_en
);
   localparam cbd_addr_t BASE_M = BASE_ADDR & ADDR_MASK;

   logic hit;

   if (ADDR_MASK == '1) begin : g_exact
      assign hit = (addr == BASE_ADDR);
   end else begin : g_masked
      assign hit = ((addr & ADDR_MASK) == BASE_M);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= frame_end && hit;
         if (frame_end && hit) begin
            wr_addr <= addr[LOCAL_AW-1:0];
            wr_data <= data_in;
         end
      end
   end
endmodule

// File: rtl/cmd_byte_decoder.sv
module cmd_byte_decoder
   import cbd_pkg::*;
#(
   parameter logic [15:0] BASE_ADDR   = 16'h0140,
   parameter logic [15:0] ADDR_MASK   = 16'hFFF0,
   parameter int          FRAME_BYTES = 6,
   parameter int          LOCAL_AW    = 4,
   localparam int         DATA_W      = 8 * (FRAME_BYTES - 2)
)(
   input  logic                clk,
   input  logic                rst,
   input  logic [7:0]          cmd_byte,
   input  logic                cmd_first,
   output logic [LOCAL_AW-1:0] wr_addr,
   output logic [DATA_W-1:0]   wr_data,
   output logic                wr_en
);
   localparam int POS_W = $clog2(FRAME_BYTES);

   if (FRAME_BYTES < MIN_FRAME || FRAME_BYTES > MAX_FRAME) begin : g_bad_frame
      $error("cmd_byte_decoder: FRAME_BYTES must be 3..6");
   end
   if (LOCAL_AW < 1 || LOCAL_AW > ADDR_W) begin : g_bad_aw
      $error("cmd_byte_decoder: LOCAL_AW must be 1..16");
   end

   logic [POS_W-1:0]  slot;
   logic              slot_vld;
   logic              frame_end;
   logic [POS_W-1:0]  pos_q;
   cbd_addr_t         addr_q;
   logic [DATA_W-1:0] data_next;

   cbd_framer #(.FRAME_BYTES(FRAME_BYTES)) u_framer (
      .clk       (clk),
      .rst       (rst),
      .first     (cmd_first),
      .slot      (slot),
      .slot_vld  (slot_vld),
      .frame_end (frame_end),
      .pos_q     (pos_q)
   );

   cbd_collect #(.FRAME_BYTES(FRAME_BYTES)) u_collect (
      .clk       (clk),
      .rst       (rst),
      .din       (cmd_byte),
      .slot      (slot),
      .slot_vld  (slot_vld),
      .addr_q    (addr_q),
      .data_next (data_next)
   );

   cbd_decode #(
      .BASE_ADDR (BASE_ADDR),
      .ADDR_MASK (ADDR_MASK),
      .LOCAL_AW  (LOCAL_AW),
      .DATA_W    (DATA_W)
   ) u_decode (
      .clk       (clk),
      .rst       (rst),
      .frame_end (frame_end),
      .addr      (addr_q),
      .data_in   (data_next),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_en     (wr_en)
   );
endmodule

// File: rtl/cmd_byte_decoder_chk.sv
module cmd_byte_decoder_chk #(
   parameter int FRAME_BYTES = 6,
   parameter int LOCAL_AW    = 4,
   parameter int DATA_W      = 32,
   localparam int POS_W = $clog2(FRAME_BYTES)
)(
   input logic                clk,
   input logic                rst,
   input logic                cmd_first,
   input logic [POS_W-1:0]    pos,
   input logic                wr_en,
   input logic [LOCAL_AW-1:0] wr_addr,
   input logic [DATA_W-1:0]   wr_data
);
   // R5
   wr_en_single_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> !wr_en);

   // R5
   wr_en_after_last_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> ($past(pos) == POS_W'(FRAME_BYTES - 1) && !$past(cmd_first)));

   // R4
   outputs_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && !$past(rst)) |-> ($stable(wr_addr) && $stable(wr_data)));

   // R8
   restart_chk: assert property (@(posedge clk) disable iff (rst)
      cmd_first |=> (pos == POS_W'(1)));

   // R2
   idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      (pos == '0 && !cmd_first) |=> (pos == '0 && !wr_en));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!wr_en && pos == '0 && wr_addr == '0 && wr_data == '0));
endmodule

bind cmd_byte_decoder cmd_byte_decoder_chk #(
   .FRAME_BYTES (FRAME_BYTES),
   .LOCAL_AW    (LOCAL_AW),
   .DATA_W      (DATA_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cmd_first (cmd_first),
   .pos       (pos_q),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data)
);

// File: tb/cmd_byte_decoder_test.sv
`timescale 1ns/1ps
module cmd_byte_decoder_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  cmd_byte = '0;
   logic        cmd_first = 1'b0;
   logic [3:0]  wr_addr;
   logic [31:0] wr_data;
   logic        wr_en;

   int n_chk = 0;
   int n_fail = 0;
   int we_seen = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   cmd_byte_decoder #(
      .BASE_ADDR(16'h0140), .ADDR_MASK(16'hFFF0), .FRAME_BYTES(6), .LOCAL_AW(4)
   ) uut (
      .clk(clk), .rst(rst), .cmd_byte(cmd_byte), .cmd_first(cmd_first),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en)
   );

   always @(posedge clk) if (wr_en === 1'b1) we_seen <= we_seen + 1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] byte_of(input logic [15:0] a, input logic [31:0] d, input int i);
      if (i == 0) return a[7:0];
      if (i == 1) return a[15:8];
      return d[8*(i-2) +: 8];
   endfunction

   // Drive bytes lo..hi of a command; the marker goes with byte 0 only.
   task automatic drive(input logic [15:0] a, input logic [31:0] d, input int lo, input int hi);
      for (int i = lo; i <= hi; i++) begin
         @(negedge clk);
         cmd_byte  = byte_of(a, d, i);
         cmd_first = (i == 0);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      cmd_byte = '0;
      cmd_first = 1'b0;
   endtask

   task automatic t_reset();
      chk("R9 reset wr_en", wr_en, 0);
      chk("R9 reset wr_addr", wr_addr, 0);
      chk("R9 reset wr_data", wr_data, 0);
   endtask

   task automatic t_match(input logic [15:0] a, input logic [31:0] d, input string tag);
      int base = we_seen;
      drive(a, d, 0, 5);
      idle();
      chk({tag, " R5 wr_en high after last byte"}, wr_en, 1);
      chk({tag, " R7 wr_addr"}, wr_addr, a[3:0]);
      chk({tag, " R6 R1 wr_data"}, wr_data, d);
      idle();
      chk({tag, " R5 wr_en one cycle"}, wr_en, 0);
      chk({tag, " R3 pulse count"}, we_seen - base, 1);
   endtask

   task automatic t_mismatch(input logic [15:0] a, input logic [31:0] d);
      int base = we_seen;
      logic [3:0]  pa = wr_addr;
      logic [31:0] pd = wr_data;
      drive(a, d, 0, 5);
      idle(); idle();
      chk("R4 R3 no pulse on mismatch", we_seen - base, 0);
      chk("R4 wr_addr held", wr_addr, pa);
      chk("R4 wr_data held", wr_data, pd);
   endtask

   task automatic t_no_marker();
      int base = we_seen;
      logic [31:0] pd = wr_data;
      drive(16'h0142, 32'h11223344, 1, 5);
      drive(16'h0142, 32'h11223344, 1, 5);
      idle(); idle();
      chk("R2 bytes without marker ignored", we_seen - base, 0);
      chk("R2 data unchanged", wr_data, pd);
   endtask

   task automatic t_restart();
      int base = we_seen;
      drive(16'h0145, 32'hDEADBEEF, 0, 3);
      drive(16'h0149, 32'h0BADF00D, 0, 5);
      idle();
      chk("R8 restart wr_en", wr_en, 1);
      chk("R8 restart wr_addr", wr_addr, 4'h9);
      chk("R8 restart wr_data", wr_data, 32'h0BADF00D);
      idle();
      chk("R8 one pulse only", we_seen - base, 1);
   endtask

   task automatic t_reset_mid();
      int base = we_seen;
      drive(16'h0146, 32'hCAFE1234, 0, 2);
      @(negedge clk);
      cmd_first = 1'b0; cmd_byte = '0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      drive(16'h0146, 32'hCAFE1234, 3, 5);
      idle(); idle();
      chk("R9 no pulse after mid-frame reset", we_seen - base, 0);
      chk("R9 wr_data cleared", wr_data, 0);
      chk("R9 wr_addr cleared", wr_addr, 0);
   endtask

   task automatic t_back_to_back();
      int base = we_seen;
      drive(16'h0141, 32'h01020304, 0, 5);
      drive(16'h014E, 32'hA5A55A5A, 0, 5);
      idle();
      chk("R5 back-to-back second wr_en", wr_en, 1);
      chk("R5 back-to-back second data", wr_data, 32'hA5A55A5A);
      chk("R7 back-to-back second addr", wr_addr, 4'hE);
      idle();
      chk("R5 back-to-back pulse count", we_seen - base, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      t_match(16'h0143, 32'hA1B2C3D4, "basic");
      t_match(16'h014F, 32'hFFFFFFFF, "mask low nibble");
      t_match(16'h0140, 32'h00000000, "zero data");
      t_mismatch(16'h0153, 32'h12345678);
      t_mismatch(16'h0240, 32'h87654321);
      t_no_marker();
      t_restart();
      t_reset_mid();
      t_back_to_back();
      t_match(16'h0147, 32'h80000001, "after sequences");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R5 watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule